// File: doc/BRIEF.md
# Blocked matrix-vector multiply sequencer

This controller drives a square array of P×P processing elements that all run the same instruction in lock step. It computes y = A·x, where A is an (N·P)×(M·P) matrix held as N·M square blocks, one block per memory plane, and x is held as M P-element subvectors, one per plane in row mode (row 0 of the plane). The controller issues one instruction per clock cycle. The array itself sits outside the block.

A start pulse captures the block counts and four base plane addresses. The controller then broadcasts every subvector of x once into its own scratch plane. For each output subvector i, it forms the sum of the M point products A_ij·X_j in one accumulator plane. It then reduces that accumulator along its rows with a single recursive-doubling pass: log2(P) steps, each made of westward unit rotations followed by one block add, with the rotation count doubling from step to step. The last add of each pass writes the reduced block, in which every column holds y_i, straight into the output plane. A one-cycle done pulse closes the operation.

Top module: `mvm_block_seq`

## Requirements
- R1: After a start is accepted, the first M instructions are broadcasts (op 1), with j = 0..M-1 in order: destination scr_base+j, source A x_base+j, source B 0. No broadcast appears anywhere else in the run.
- R2: For each output row i = 0..N-1, M product instructions follow, with j = 0..M-1. The first is a multiply (op 2, dst = sa.*sb) and the rest are multiply-accumulates (op 3, dst = dst + sa.*sb). Each has destination ACC = scr_base+MAXB, source A a_base+i·M+j and source B scr_base+j.
- R3: After the products of a row come L = log2(P) reduction steps. Step k consists of 2^k west rotations (op 4, dst[r][c] = sa[r][(c+1) mod P]) into TMP = scr_base+MAXB+1, followed by one add (op 5, dst = sa+sb) with source A ACC and source B TMP. The first rotation of a step reads ACC and every later rotation reads TMP. Source B of a rotation is 0.
- R4: The add that closes the final reduction step of row i writes y_base+i. Every other add writes ACC.
- R5: Instructions are issued on consecutive cycles with ins_valid high, M + N·(M + P − 1 + log2 P) in total.
- R6: done is high for exactly one cycle, the cycle after the last instruction. ins_valid is low in that cycle.
- R7: A start pulse while instructions are being issued has no effect on the running sequence or on its length.
- R8: Run on a behavioural array, the sequence leaves y_i[r][c] = Σ_j Σ_c' A_ij[r][c']·x_j[c'] in plane y_base+i for every column c.
- R9: During and after reset, until a start is accepted, ins_valid = 0, ins_op = 0 and done = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, taken only when idle |
| m_blks | input | CW | Column block count M (1..MAXB) |
| n_blks | input | CW | Row block count N (1..MAXB) |
| a_base | input | AW | Plane of block A_00; blocks are row-major |
| x_base | input | AW | Plane of subvector x_0 |
| y_base | input | AW | Plane of output subvector y_0 |
| scr_base | input | AW | First scratch plane (X copies, ACC, TMP) |
| ins_valid | output | 1 | An instruction is issued this cycle |
| ins_op | output | 3 | Opcode: 0 none, 1 broadcast, 2 multiply, 3 multiply-accumulate, 4 rotate west, 5 add |
| ins_dst | output | AW | Destination plane |
| ins_sa | output | AW | Source plane A |
| ins_sb | output | AW | Source plane B (0 when unused) |
| done | output | 1 | One-cycle completion pulse |

## Verification
The first instruction is issued in the cycle after the edge that samples start. Instruction t of the run falls t cycles later, and done comes one cycle after the last instruction. The bench samples every output on the falling edge and records the cycle number of each sample. It then compares the recorded cycles against these offsets, and the recorded instructions against a sequence it builds from the requirements. It also executes each recorded instruction on a behavioural plane memory and compares the resulting output planes with a direct matrix-vector product.

// File: rtl/mvm_block_seq.sv
module mvm_block_seq #(
  parameter int P    = 4,
  parameter int MAXB = 4,
  parameter int AW   = 8,
  localparam int L   = $clog2(P),
  localparam int CW  = $clog2(MAXB + 1),
  localparam int KW  = (L > 1) ? $clog2(L) : 1,
  localparam int RW  = (L > 0) ? L : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] m_blks,
  input  logic [CW-1:0] n_blks,
  input  logic [AW-1:0] a_base,
  input  logic [AW-1:0] x_base,
  input  logic [AW-1:0] y_base,
  input  logic [AW-1:0] scr_base,
  output logic          ins_valid,
  output logic [2:0]    ins_op,
  output logic [AW-1:0] ins_dst,
  output logic [AW-1:0] ins_sa,
  output logic [AW-1:0] ins_sb,
  output logic          done
);
  localparam logic [2:0] OP_NOP = 3'd0, OP_BC = 3'd1, OP_MUL = 3'd2,
                         OP_MAC = 3'd3, OP_ROT = 3'd4, OP_ADD = 3'd5;

  typedef enum logic [2:0] {S_IDLE, S_BC, S_MAC, S_ROT, S_ADD} st_t;
  st_t st;

  logic [CW-1:0] m_r, n_r, j, i;
  logic [AW-1:0] ab, xb, yb, sb, a_ptr;
  logic [KW-1:0] k;
  logic [RW-1:0] r, rmax;

  wire j_last = (j == m_r - CW'(1));
  wire i_last = (i == n_r - CW'(1));
  wire k_last = (k == KW'(L - 1));
  assign rmax = RW'((32'd1 << k) - 32'd1);
  wire r_last = (r == rmax);

  wire [AW-1:0] acc_pl = sb + AW'(MAXB);
  wire [AW-1:0] tmp_pl = sb + AW'(MAXB + 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; done <= 1'b0;
      m_r <= '0; n_r <= '0; j <= '0; i <= '0; k <= '0; r <= '0;
      ab <= '0; xb <= '0; yb <= '0; sb <= '0; a_ptr <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          m_r <= m_blks; n_r <= n_blks;
          ab <= a_base; xb <= x_base; yb <= y_base; sb <= scr_base;
          a_ptr <= a_base; j <= '0; i <= '0;
          st <= S_BC;
        end
        S_BC: if (j_last) begin
          j <= '0; st <= S_MAC;
        end else j <= j + CW'(1);
        S_MAC: begin
          a_ptr <= a_ptr + AW'(1);
          if (j_last) begin
            j <= '0; k <= '0; r <= '0; st <= S_ROT;
          end else j <= j + CW'(1);
        end
        S_ROT: if (r_last) begin
          r <= '0; st <= S_ADD;
        end else r <= r + RW'(1);
        S_ADD: if (k_last) begin
          if (i_last) begin
            st <= S_IDLE; done <= 1'b1;
          end else begin
            i <= i + CW'(1); st <= S_MAC;
          end
        end else begin
          k <= k + KW'(1); st <= S_ROT;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign ins_valid = (st != S_IDLE);

  always_comb begin
    ins_op = OP_NOP; ins_dst = '0; ins_sa = '0; ins_sb = '0;
    case (st)
      S_BC: begin
        ins_op = OP_BC; ins_dst = sb + AW'(j); ins_sa = xb + AW'(j);
      end
      S_MAC: begin
        ins_op = (j == '0) ? OP_MUL : OP_MAC;
        ins_dst = acc_pl; ins_sa = a_ptr; ins_sb = sb + AW'(j);
      end
      S_ROT: begin
        ins_op = OP_ROT; ins_dst = tmp_pl;
        ins_sa = (r == '0) ? acc_pl : tmp_pl;
      end
      S_ADD: begin
        ins_op = OP_ADD; ins_dst = k_last ? (yb + AW'(i)) : acc_pl;
        ins_sa = acc_pl; ins_sb = tmp_pl;
      end
      default: ;
    endcase
  end

  assert_bcast_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_op == OP_BC) |-> ($past(ins_op) == OP_BC || $past(ins_op) == OP_NOP));
  assert_mac_chain_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_op == OP_MAC) |-> ($past(ins_op) == OP_MUL || $past(ins_op) == OP_MAC));
  assert_add_after_rot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_op == OP_ADD) |-> ($past(ins_op) == OP_ROT));
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_after_add_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!ins_valid && $past(ins_op) == OP_ADD));
  assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && start && ins_op != OP_ADD) |=> ins_valid);
endmodule

// File: tb/sim_mvm_block_seq.sv
module sim_mvm_block_seq;
  localparam int P = 4, MAXB = 4, AW = 8;
  localparam int L = $clog2(P), CW = $clog2(MAXB + 1);

  logic clk = 0, rst_n = 0, start = 0;
  logic [CW-1:0] m_blks = 0, n_blks = 0;
  logic [AW-1:0] a_base = 0, x_base = 0, y_base = 0, scr_base = 0;
  logic ins_valid, done;
  logic [2:0] ins_op;
  logic [AW-1:0] ins_dst, ins_sa, ins_sb;

  mvm_block_seq #(.P(P), .MAXB(MAXB), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .m_blks(m_blks), .n_blks(n_blks),
    .a_base(a_base), .x_base(x_base), .y_base(y_base), .scr_base(scr_base),
    .ins_valid(ins_valid), .ins_op(ins_op), .ins_dst(ins_dst), .ins_sa(ins_sa),
    .ins_sb(ins_sb), .done(done));

  always #4 clk = ~clk;

  int checks = 0, failures = 0, cyc = 0, finished = 0;
  int pl [0:255][0:P-1][0:P-1];
  int tb_t [0:P-1][0:P-1];
  int n_got = 0, done_cnt = 0, done_cyc = 0;
  int g_op [0:127], g_dst [0:127], g_sa [0:127], g_sb [0:127], g_cyc [0:127];
  int e_op [0:127], e_dst [0:127], e_sa [0:127], e_sb [0:127];
  int n_exp = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (done) begin done_cnt++; done_cyc = cyc; end
    if (ins_valid) begin
      if (n_got < 128) begin
        g_op[n_got] = ins_op; g_dst[n_got] = ins_dst; g_sa[n_got] = ins_sa;
        g_sb[n_got] = ins_sb; g_cyc[n_got] = cyc;
      end
      n_got++;
      for (int r = 0; r < P; r++)
        for (int c = 0; c < P; c++)
          case (ins_op)
            3'd1: tb_t[r][c] = pl[ins_sa][0][c];
            3'd2: tb_t[r][c] = pl[ins_sa][r][c] * pl[ins_sb][r][c];
            3'd3: tb_t[r][c] = pl[ins_dst][r][c] + pl[ins_sa][r][c] * pl[ins_sb][r][c];
            3'd4: tb_t[r][c] = pl[ins_sa][r][(c + 1) % P];
            3'd5: tb_t[r][c] = pl[ins_sa][r][c] + pl[ins_sb][r][c];
            default: tb_t[r][c] = pl[ins_dst][r][c];
          endcase
      for (int r = 0; r < P; r++)
        for (int c = 0; c < P; c++) pl[ins_dst][r][c] = tb_t[r][c];
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic push(input int op, input int d, input int a, input int b);
    e_op[n_exp] = op; e_dst[n_exp] = d; e_sa[n_exp] = a; e_sb[n_exp] = b; n_exp++;
  endtask

  task automatic run_case(input int m, input int n, input int ab, input int xb,
                          input int yb, input int sb, input int seed, input bit poke);
    int acc, tmp, wait_n, bad_cat [4], first_bad [4], y_bad, y_act, y_exp;
    acc = sb + MAXB; tmp = sb + MAXB + 1;
    for (int i = 0; i < n; i++)
      for (int j = 0; j < m; j++)
        for (int r = 0; r < P; r++)
          for (int c = 0; c < P; c++)
            pl[ab + i*m + j][r][c] = ((i*7 + j*5 + r*3 + c + seed) % 11) - 5;
    for (int j = 0; j < m; j++)
      for (int r = 0; r < P; r++)
        for (int c = 0; c < P; c++)
          pl[xb + j][r][c] = (r == 0) ? ((j*3 + c*2 + seed) % 7) - 3 : 99;
    n_exp = 0;
    for (int j = 0; j < m; j++) push(1, sb + j, xb + j, 0);
    for (int i = 0; i < n; i++) begin
      for (int j = 0; j < m; j++) push(j == 0 ? 2 : 3, acc, ab + i*m + j, sb + j);
      for (int k = 0; k < L; k++) begin
        for (int r = 0; r < (1 << k); r++) push(4, tmp, r == 0 ? acc : tmp, 0);
        push(5, k == L-1 ? yb + i : acc, acc, tmp);
      end
    end
    @(posedge clk); #1;
    n_got = 0; done_cnt = 0;
    m_blks = CW'(m); n_blks = CW'(n); a_base = AW'(ab); x_base = AW'(xb);
    y_base = AW'(yb); scr_base = AW'(sb); start = 1;
    @(posedge clk); #1; start = 0;
    if (poke) begin
      repeat (4) @(posedge clk); #1;
      m_blks = 1; n_blks = 1; a_base = 50; x_base = 60; y_base = 70; scr_base = 80; start = 1;
      @(posedge clk); #1; start = 0;
    end
    wait_n = 0;
    while (done_cnt == 0 && wait_n < 500) begin @(posedge clk); wait_n++; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(n_got == n_exp, poke ? "R7" : "R5", "instruction count", n_got, n_exp);
    for (int q = 0; q < 4; q++) begin bad_cat[q] = 0; first_bad[q] = -1; end
    for (int t = 0; t < n_exp && t < n_got; t++) begin
      int cat;
      cat = (e_op[t] == 1) ? 0 : (e_op[t] <= 3) ? 1 : (e_op[t] == 4) ? 2 : 3;
      if (g_op[t] != e_op[t] || g_dst[t] != e_dst[t] || g_sa[t] != e_sa[t] || g_sb[t] != e_sb[t]) begin
        if (bad_cat[cat] == 0) first_bad[cat] = t;
        bad_cat[cat]++;
      end
    end
    check(bad_cat[0] == 0, "R1", "broadcast mismatches", bad_cat[0], 0);
    check(bad_cat[1] == 0, "R2", "product mismatches", bad_cat[1], 0);
    check(bad_cat[2] == 0, "R3", "rotation mismatches", bad_cat[2], 0);
    check(bad_cat[3] == 0, "R4", "add mismatches", bad_cat[3], 0);
    for (int q = 0; q < 4; q++)
      if (first_bad[q] >= 0)
        $display("  first mismatch at slot %0d: op=%0d dst=%0d sa=%0d sb=%0d exp op=%0d dst=%0d sa=%0d sb=%0d",
          first_bad[q], g_op[first_bad[q]], g_dst[first_bad[q]], g_sa[first_bad[q]], g_sb[first_bad[q]],
          e_op[first_bad[q]], e_dst[first_bad[q]], e_sa[first_bad[q]], e_sb[first_bad[q]]);
    begin
      int gaps = 0;
      for (int t = 1; t < n_got && t < 128; t++) if (g_cyc[t] != g_cyc[0] + t) gaps++;
      check(gaps == 0, "R5", "non-consecutive issue slots", gaps, 0);
    end
    check(done_cnt == 1 && n_got > 0 && done_cyc == g_cyc[(n_got - 1) % 128] + 1, "R6",
          "done pulses / cycle offset", done_cnt, 1);
    y_bad = 0; y_act = 0; y_exp = 0;
    for (int i = 0; i < n; i++)
      for (int r = 0; r < P; r++) begin
        int s = 0;
        for (int j = 0; j < m; j++)
          for (int c = 0; c < P; c++) s += pl[ab + i*m + j][r][c] * pl[xb + j][0][c];
        for (int c = 0; c < P; c++)
          if (pl[yb + i][r][c] != s) begin
            if (y_bad == 0) begin y_act = pl[yb + i][r][c]; y_exp = s; end
            y_bad++;
          end
      end
    check(y_bad == 0, "R8", "first wrong y element", y_act, y_exp);
    check(ins_valid == 0 && done == 0, "R9", "idle outputs after run", ins_valid, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(ins_valid == 0 && ins_op == 0 && done == 0, "R9", "reset outputs", {ins_valid, ins_op, done}, 0);
    @(posedge clk); #1; rst_n = 1;
    @(negedge clk);
    check(ins_valid == 0 && done == 0, "R9", "idle after reset", ins_valid, 0);
    run_case(1, 1, 0, 100, 120, 200, 1, 0);
    run_case(3, 2, 10, 104, 124, 210, 4, 0);
    run_case(4, 4, 20, 108, 130, 220, 2, 0);
    run_case(2, 3, 40, 112, 140, 230, 6, 1);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule